// File: doc/BRIEF.md
# Direct-Sequence Bit-to-Chip Spreader

This block turns the bits of a short 2.4 GHz IEEE 802.15.4 packet into a serial stream of spreading chips. Packet bits arrive one at a time at the data rate. A one-cycle `data_tick` strobe marks each data bit. The strobe is produced from the chip clock by a divide-by-8 enable, so one data bit spans eight chip periods. The block collects the bits into a packet buffer. A `load` strobe takes a snapshot of the buffer and arms the spreader.

Every octet is cut into two 4-bit symbols, and the low nibble is taken first. Each symbol picks one of sixteen 32-chip pseudo-noise words. While `shift_en` is high, the chips leave on `chip_out` at one chip per clock, least significant chip first. With the default 11-octet packet there are 22 symbols and 704 chips. One clock after the final chip, `done` pulses and the output rests at 0.

Top module: `dsss_bit_to_chip`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register. After it, `chip_out` and `done` are 0 and the packet buffer holds all zeros.
- R2: `bit_in` is captured only on an edge where `data_tick` is 1. The first captured bit becomes packet bit 0, which is bit b0 of the first octet. Packet bit 8k+i is bit b_i of octet k.
- R3: Octet k gives symbol 2k from its bits b0..b3 (b0 = symbol LSB), then symbol 2k+1 from b4..b7. Symbols go out in increasing order.
- R4: Symbol 0 spreads to the word 0x744AC39B. Chip c is bit c of the word, so the chips start 1, 1, 0. Symbol s in 1..7 is the symbol-0 word delayed by 4·s chips: chip c equals symbol-0 chip (c − 4s) mod 32. Symbol s+8 is symbol s with every odd-numbered chip inverted.
- R5: Within a symbol, chip c0 is sent first and c31 last. Each chip appears on `chip_out` one clock after the edge that sampled `shift_en` high.
- R6: `load` takes priority over `shift_en`. On a load edge no chip is emitted, `chip_out` goes to 0 and `done` goes to 0. The next emitted chip is chip 0 of symbol 0 of the freshly captured packet, even if a transmission was under way.
- R7: On an edge where `shift_en` is 0 and `load` is 0, `chip_out` goes to 0 and the chip position holds. The next chip emitted is the one that was due.
- R8: After 16·PKT_OCTETS·4 chips (704 by default) the spreader stops. `done` is 1 for exactly the one clock that follows the last chip, and `chip_out` is 0 during that clock.
- R9: When no transmission is armed (after reset or after completion), `shift_en` emits nothing: `chip_out` stays 0 and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous reset, active high |
| data_tick | input | 1 | Data-bit enable, one cycle in eight |
| bit_in | input | 1 | Serial packet bit, sampled on `data_tick` |
| load | input | 1 | Snapshot the packet buffer and restart spreading |
| shift_en | input | 1 | Emit one chip per clock when armed |
| chip_out | output | 1 | Serial chip output |
| done | output | 1 | One-clock pulse after the final chip |

## Verification
The first packet is sent right after reset with no bits fed. This all-zero packet is symbol 0 repeated, so it pins the base word and the 1, 1, 0 start without depending on nibble order. A directed packet whose octets hold distinct low and high nibbles separates correct nibble ordering from swapped or octet-reversed ordering. Random packets reach all sixteen words, so they catch an error in the rotation direction or in the odd-chip inversion. Random pauses in `shift_en`, a reload partway through a transmission, and `bit_in` toggling between ticks show that the chip position holds, that the restart is clean, and that the input is sampled only on the strobe.

// File: rtl/b2c_pkg.sv
package b2c_pkg;
  localparam int SYM_W    = 4;
  localparam int OCT_W    = 8;
  localparam int CHIPS    = 32;
  localparam int N_WORDS  = 1 << SYM_W;
  localparam int ROT_STEP = 4;
  localparam int CIDX_W   = $clog2(CHIPS);

  localparam logic [CHIPS-1:0] SEED_WORD = 32'h744AC39B;
  localparam logic [CHIPS-1:0] ODD_FLIP  = 32'hAAAAAAAA;

  typedef logic [CHIPS-1:0] chip_word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} run_t;

  // Spreading word for one symbol: low three bits pick a chip delay,
  // the top bit inverts odd chips.
  function automatic chip_word_t spread_word(input logic [SYM_W-1:0] sym);
    chip_word_t w;
    int sh;
    sh = ROT_STEP * int'(sym[SYM_W-2:0]);
    w  = (SEED_WORD << sh) | (SEED_WORD >> (CHIPS - sh));
    if (sh == 0) w = SEED_WORD;
    if (sym[SYM_W-1]) w = w ^ ODD_FLIP;
    return w;
  endfunction
endpackage

// File: rtl/b2c_chip_lut.sv
module b2c_chip_lut
  import b2c_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output chip_word_t       word
);
  chip_word_t tbl [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_ent
    assign tbl[g] = spread_word(SYM_W'(g));
  end

  assign word = tbl[sym];
endmodule

// File: rtl/b2c_bit_collector.sv
module b2c_bit_collector #(
  parameter int PKT_BITS = 88
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                data_tick,
  input  logic                bit_in,
  output logic [PKT_BITS-1:0] pkt
);
  logic [PKT_BITS-1:0] pkt_q;

  // New bits enter at the top and move down, so the first one ends at bit 0.
  always_ff @(posedge clk) begin
    if (rst)            pkt_q <= '0;
    else if (data_tick) pkt_q <= {bit_in, pkt_q[PKT_BITS-1:1]};
  end

  assign pkt = pkt_q;

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !data_tick |=> $stable(pkt_q));
  a_r2_entry_bit: assert property (@(posedge clk) disable iff (rst)
    data_tick |=> (pkt_q[PKT_BITS-1] == $past(bit_in)));
endmodule

// File: rtl/b2c_spreader.sv
module b2c_spreader
  import b2c_pkg::*;
#(
  parameter int PKT_BITS = 88
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift_en,
  input  logic [PKT_BITS-1:0] pkt,
  output logic                chip_out,
  output logic                done
);
  localparam int NSYM  = PKT_BITS / SYM_W;
  localparam int SIDX_W = $clog2(NSYM);

  run_t              st;
  logic [SIDX_W-1:0] sym_idx;
  logic [CIDX_W-1:0] chip_idx;
  chip_word_t        creg;
  logic [PKT_BITS-1:0] pkt_q;

  logic [SYM_W-1:0] sym_sel;
  chip_word_t       lut_word;

  // Named events for the assertions.
  logic emit_w, sym_end_w, last_emit_w;

  function automatic logic [SYM_W-1:0] pick_sym(input logic [PKT_BITS-1:0] v,
                                                input int idx);
    logic [SYM_W-1:0] r;
    r = '0;
    if (idx < NSYM)
      for (int b = 0; b < SYM_W; b++) r[b] = v[idx*SYM_W + b];
    return r;
  endfunction

  always_comb begin
    if (load) sym_sel = pick_sym(pkt, 0);
    else      sym_sel = pick_sym(pkt_q, int'(sym_idx) + 1);
  end

  b2c_chip_lut u_lut (.sym(sym_sel), .word(lut_word));

  assign emit_w      = !load && shift_en && (st == ST_RUN);
  assign sym_end_w   = emit_w && (chip_idx == CIDX_W'(CHIPS-1));
  assign last_emit_w = sym_end_w && (sym_idx == SIDX_W'(NSYM-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sym_idx  <= '0;
      chip_idx <= '0;
      creg     <= '0;
      pkt_q    <= '0;
      chip_out <= 1'b0;
      done     <= 1'b0;
    end else if (load) begin
      pkt_q    <= pkt;
      creg     <= lut_word;
      sym_idx  <= '0;
      chip_idx <= '0;
      st       <= ST_RUN;
      chip_out <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= (st == ST_FIN);
      chip_out <= emit_w ? creg[0] : 1'b0;
      if (st == ST_FIN) st <= ST_IDLE;
      if (emit_w) begin
        if (last_emit_w) begin
          st <= ST_FIN;
        end else if (sym_end_w) begin
          sym_idx  <= sym_idx + 1'b1;
          chip_idx <= '0;
          creg     <= lut_word;
        end else begin
          creg     <= creg >> 1;
          chip_idx <= chip_idx + 1'b1;
        end
      end
    end
  end

  a_r6_load_quiet: assert property (@(posedge clk) disable iff (rst)
    load |=> (!chip_out && !done));
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load) |=> !chip_out);
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(last_emit_w, 2));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !chip_out);
  a_r9_no_emit_unarmed: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && !load) |=> !chip_out);
  a_r3_sym_bound: assert property (@(posedge clk) disable iff (rst)
    sym_idx <= SIDX_W'(NSYM-1));
endmodule

// File: rtl/dsss_bit_to_chip.sv
module dsss_bit_to_chip #(
  parameter int PKT_OCTETS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic data_tick,
  input  logic bit_in,
  input  logic load,
  input  logic shift_en,
  output logic chip_out,
  output logic done
);
  localparam int PKT_BITS = PKT_OCTETS * b2c_pkg::OCT_W;

  logic [PKT_BITS-1:0] pkt;

  b2c_bit_collector #(.PKT_BITS(PKT_BITS)) u_coll (
    .clk(clk), .rst(rst), .data_tick(data_tick), .bit_in(bit_in), .pkt(pkt)
  );

  b2c_spreader #(.PKT_BITS(PKT_BITS)) u_spr (
    .clk(clk), .rst(rst), .load(load), .shift_en(shift_en), .pkt(pkt),
    .chip_out(chip_out), .done(done)
  );

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!chip_out && !done));
endmodule

// File: tb/dsss_bit_to_chip_tb.sv
module dsss_bit_to_chip_tb;
  localparam int PB = 88;
  localparam int NCHIP = PB / 4 * 32;

  logic clk = 1'b0, rst = 1'b1, data_tick = 1'b0, bit_in = 1'b0;
  logic load = 1'b0, shift_en = 1'b0;
  logic chip_out, done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dsss_bit_to_chip u_dut (
    .clk(clk), .rst(rst), .data_tick(data_tick), .bit_in(bit_in),
    .load(load), .shift_en(shift_en), .chip_out(chip_out), .done(done)
  );

  function automatic bit exp_chip(logic [PB-1:0] p, int k);
    int s, c, sym, src;
    logic [31:0] base;
    bit b;
    base = 32'h744AC39B;
    s = k / 32; c = k % 32;
    sym = p[4*s] + 2*p[4*s+1] + 4*p[4*s+2] + 8*p[4*s+3];
    src = (c - 4*(sym % 8) + 64) % 32;
    b = base[src];
    if (sym >= 8 && (c % 2) == 1) b = !b;
    return b;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic feed(logic [PB-1:0] p);
    for (int i = 0; i < PB; i++)
      for (int ph = 0; ph < 8; ph++) begin
        @(negedge clk);
        data_tick = (ph == 7);
        bit_in = (ph == 7) ? p[i] : 1'($urandom);  // R2: off-tick noise
      end
    @(negedge clk);
    data_tick = 0; bit_in = 0;
  endtask

  task automatic run_pkt(logic [PB-1:0] p, int pause_pct, int abort_at);
    int k = 0;
    bit ab = 0;
    load = 1; shift_en = 0;
    @(negedge clk);
    chk(chip_out == 0 && done == 0, "R6 load edge", chip_out, 0);
    load = 0;
    while (k < NCHIP) begin
      bit sh, lo;
      sh = (($urandom % 100) >= pause_pct);
      lo = (k == abort_at) && !ab;
      load = lo; shift_en = lo ? 1'b1 : sh;
      @(negedge clk);
      if (lo) begin
        chk(chip_out == 0, "R6 reload mid-run", chip_out, 0);
        k = 0; ab = 1;
      end else if (sh) begin
        chk(chip_out == exp_chip(p, k), "R4 R5 R3 chip", chip_out, exp_chip(p, k));
        k++;
      end else begin
        chk(chip_out == 0, "R7 pause", chip_out, 0);
      end
      chk(done == 0, "R8 early done", done, 0);
    end
    load = 0; shift_en = 1'($urandom);
    @(negedge clk);
    chk(done == 1, "R8 done pulse", done, 1);
    chk(chip_out == 0, "R8 output rests", chip_out, 0);
    shift_en = 1;
    @(negedge clk);
    chk(done == 0, "R8 single pulse", done, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(chip_out == 0 && done == 0, "R9 shift after done", chip_out, 0);
    end
    shift_en = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    logic [PB-1:0] p;
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    chk(chip_out == 0 && done == 0, "R1 reset state", chip_out, 0);
    rst = 0;
    shift_en = 1;
    repeat (4) begin
      @(negedge clk);
      chk(chip_out == 0, "R9 shift before load", chip_out, 0);
    end
    shift_en = 0;
    // R1: buffer cleared by reset, so first packet is all symbol 0
    load = 1;
    @(negedge clk);
    load = 0; shift_en = 1;
    @(negedge clk); chk(chip_out == 1, "R4 first chip", chip_out, 1);
    @(negedge clk); chk(chip_out == 1, "R4 second chip", chip_out, 1);
    @(negedge clk); chk(chip_out == 0, "R4 third chip", chip_out, 0);
    run_pkt('0, 0, -1);
    // R3: distinct nibbles per octet
    for (int o = 0; o < PB / 8; o++) p[8*o +: 8] = 8'((o % 8) | (((o + 9) % 16) << 4));
    feed(p);
    run_pkt(p, 0, -1);
    // random packets with pauses, one with a mid-run reload (R6, R7)
    p = {24'($urandom), 32'($urandom), 32'($urandom)};
    feed(p);
    run_pkt(p, 30, -1);
    p = {24'($urandom), 32'($urandom), 32'($urandom)};
    feed(p);
    run_pkt(p, 20, 300);
    // R1: reset during a run
    load = 1; @(negedge clk); load = 0; shift_en = 1;
    repeat (40) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk(chip_out == 0 && done == 0, "R1 reset mid-run", chip_out, 0);
    repeat (3) begin
      @(negedge clk);
      chk(chip_out == 0, "R1 R9 no emission after reset", chip_out, 0);
    end
    shift_en = 0;
    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "R8 watchdog", 0, 1);
      summary();
    end
  end
endmodule